// File: doc/BRIEF.md
# Self-Clocked Serial Register Write Port

This block receives configuration words from a host over a serial link in which the receiving side, not the host, drives the serial clock. The host pulls an active-low frame-sync line low and holds it there. The block then turns on its clock output and drives a burst of clock pulses derived from the system clock. It samples one data bit from the host on each rising clock edge, starting with the most significant bit. After the last bit it stops the clock by itself and stops driving the line.

A select input decides which of two 24-bit destination registers receives the word: the control register or the calibration register. The select value is captured when the frame begins. A destination is written in one step, and only once every bit of the frame has arrived. A frame that the host ends early leaves both registers as they were. When no frame is running, the clock output enable is low, so an external pull-up holds the shared clock line high.

Top module: `sclk_wr_port`

## Requirements
- R1: After reset, `sclk_oe_o` is 0, `sclk_o` is 1, and both `ctrl_reg_o` and `cal_reg_o` are zero.
- R2: A falling edge on `fsync_ni` passes through a two-stage synchronizer. Exactly three system clock edges after the low level is first sampled, `sclk_oe_o` is 1 and `sclk_o` is 0.
- R3: A frame that completes shows exactly `WORD_W` (24) rising edges on `sclk_o` while `sclk_oe_o` is 1. `sclk_oe_o` returns to 0 one system cycle after the falling edge that follows the last rising edge.
- R4: `sdata_i` is sampled at each rising edge of `sclk_o`. The first bit sampled becomes bit `WORD_W-1` of the stored word, and the last becomes bit 0.
- R5: If `sel_i` is 0 at frame start, the word goes to `ctrl_reg_o`. If it is 1, the word goes to `cal_reg_o`. The register that was not selected does not change.
- R6: While the output is enabled, each high phase and each low phase of `sclk_o` lasts exactly `DIV_HALF` system cycles, and `DIV_HALF` is at least 2.
- R7: If `fsync_ni` returns high before all `WORD_W` bits have been sampled, the frame is aborted. `sclk_oe_o` drops, `sclk_o` parks high, and neither register changes.
- R8: Holding `fsync_ni` low after a frame has completed does not start a new frame. Only a new falling edge starts one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fsync_ni | input | 1 | Host frame sync, active low, asynchronous |
| sdata_i | input | 1 | Serial data from host |
| sel_i | input | 1 | Destination select: 0 control, 1 calibration |
| sclk_o | output | 1 | Generated serial clock value |
| sclk_oe_o | output | 1 | Serial clock output enable; low leaves the line to the pull-up |
| ctrl_reg_o | output | WORD_W | Control register contents |
| cal_reg_o | output | WORD_W | Calibration register contents |

## Verification
The bench builds the block with `WORD_W` = 24 and `DIV_HALF` = 3. An odd phase length exercises the divider's terminal count at a value other than a power of two. It also leaves enough cycles inside each high phase for an abort after bit 23 to take effect through the synchronizer before the 24th rising edge. The bench acts as the host and loads the next bit after each observed falling edge. It mixes random words, random destinations and random abort points with directed frames: all-ones and all-zeros words, single-end-bit words, aborts at the first and last possible bit, and a frame sync held low past the end of a frame.

// File: rtl/sclk_wr_pkg.sv
package sclk_wr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } wr_state_e;

  localparam int unsigned NUM_DEST = 2;
  localparam int unsigned DEST_CTRL = 0;
  localparam int unsigned DEST_CAL  = 1;

endpackage

// File: rtl/sclk_wr_sync.sv
module sclk_wr_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {STAGES{RESET_VAL}};
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/sclk_wr_clkgen.sv
module sclk_wr_clkgen #(
  parameter int unsigned DIV_HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  input  logic park_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);

  localparam int unsigned CNT_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_HALF - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             sclk_q;
  logic             tick;

  assign tick   = run_i && (cnt_q == LAST);
  assign rise_o = tick && !sclk_q;
  assign fall_o = tick && sclk_q;
  assign sclk_o = sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b1;
    end else if (start_i) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (run_i) begin
      if (tick) begin
        cnt_q  <= '0;
        sclk_q <= !sclk_q;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end else if (park_i) begin
      cnt_q  <= '0;
      sclk_q <= 1'b1;
    end
  end

  // a rising edge inside a running burst follows at least two low cycles
  AST_PHASE_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && $rose(sclk_q)) |-> ($past(sclk_q, 2) == 1'b0)); // R6

endmodule

// File: rtl/sclk_wr_shift.sv
module sclk_wr_shift #(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              sample_i,
  input  logic              sdata_i,
  output logic [WORD_W-1:0] word_o,
  output logic              full_o
);

  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);

  logic [WORD_W-1:0] sr_q;
  logic [CNT_W-1:0]  cnt_q;

  assign full_o = (cnt_q == FULL_CNT);
  assign word_o = sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (sample_i && !full_o) begin
      sr_q  <= {sr_q[WORD_W-2:0], sdata_i};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_CNT); // R3
  AST_NO_SAMPLE_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_i |-> !full_o); // R3

endmodule

// File: rtl/sclk_wr_regs.sv
module sclk_wr_regs
  import sclk_wr_pkg::*;
#(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic              sel_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] ctrl_o,
  output logic [WORD_W-1:0] cal_o
);

  logic [NUM_DEST-1:0][WORD_W-1:0] dest_q;

  for (genvar g = 0; g < NUM_DEST; g++) begin : g_dest
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     dest_q[g] <= '0;
      else if (commit_i && (sel_i == 1'(g)))           dest_q[g] <= word_i;
    end
  end

  assign ctrl_o = dest_q[DEST_CTRL];
  assign cal_o  = dest_q[DEST_CAL];

  AST_ONE_DEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_o) |-> $stable(cal_o)); // R5

endmodule

// File: rtl/sclk_wr_port.sv
module sclk_wr_port
  import sclk_wr_pkg::*;
#(
  parameter int unsigned WORD_W   = 24,
  parameter int unsigned DIV_HALF = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fsync_ni,
  input  logic              sdata_i,
  input  logic              sel_i,
  output logic              sclk_o,
  output logic              sclk_oe_o,
  output logic [WORD_W-1:0] ctrl_reg_o,
  output logic [WORD_W-1:0] cal_reg_o
);

  wr_state_e         state_q, state_d;
  logic              fsync_s, fsync_q;
  logic              start, run, park;
  logic              rise, fall, full;
  logic              sel_q;
  logic [WORD_W-1:0] word;

  sclk_wr_sync #(.STAGES(2), .RESET_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (fsync_ni),
    .q_o   (fsync_s)
  );

  assign start = (state_q == ST_IDLE) && fsync_q && !fsync_s;
  assign run   = (state_q == ST_RUN) && !fsync_s;
  assign park  = !run && !start;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_RUN;
      ST_RUN: begin
        if (fsync_s)           state_d = ST_IDLE;  // early release: abort
        else if (fall && full) state_d = ST_FIN;
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      fsync_q <= 1'b1;
      sel_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      fsync_q <= fsync_s;
      if (start) sel_q <= sel_i;
    end
  end

  sclk_wr_clkgen #(.DIV_HALF(DIV_HALF)) u_clkgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .run_i  (run),
    .park_i (park),
    .sclk_o (sclk_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  sclk_wr_shift #(.WORD_W(WORD_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (start),
    .sample_i(rise),
    .sdata_i (sdata_i),
    .word_o  (word),
    .full_o  (full)
  );

  sclk_wr_regs #(.WORD_W(WORD_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .commit_i(state_q == ST_FIN),
    .sel_i   (sel_q),
    .word_i  (word),
    .ctrl_o  (ctrl_reg_o),
    .cal_o   (cal_reg_o)
  );

  assign sclk_oe_o = (state_q != ST_IDLE);

  AST_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclk_oe_o |-> sclk_o); // R1
  AST_LOW_ONLY_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> sclk_oe_o); // R2
  AST_COMMIT_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(ctrl_reg_o) || !$stable(cal_reg_o)) |-> $past(full)); // R7
  AST_NO_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FIN && !fsync_s) |=> !sclk_oe_o); // R8

endmodule

// File: tb/sclk_wr_port_tb.sv
module sclk_wr_port_tb;
  localparam int W   = 24;
  localparam int DIV = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic fsync_ni = 1'b1;
  logic sdata_i = 1'b0;
  logic sel_i = 1'b0;
  logic sclk_o, sclk_oe_o;
  logic [W-1:0] ctrl_reg_o, cal_reg_o;

  int errs = 0;
  int checks = 0;
  bit finished = 0;
  logic [W-1:0] exp_ctrl = '0;
  logic [W-1:0] exp_cal  = '0;

  always #5 clk = ~clk;

  sclk_wr_port #(.WORD_W(W), .DIV_HALF(DIV)) u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .fsync_ni  (fsync_ni),
    .sdata_i   (sdata_i),
    .sel_i     (sel_i),
    .sclk_o    (sclk_o),
    .sclk_oe_o (sclk_oe_o),
    .ctrl_reg_o(ctrl_reg_o),
    .cal_reg_o (cal_reg_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // host model: drive next bit after each observed falling edge
  task automatic run_frame(input bit sel, input logic [W-1:0] word, input int abort_at,
                           input int hold_low, output int rises, output int lat,
                           output int phase_bad, output int rearm);
    logic prev_s;
    int run_len;
    sel_i = sel;
    sdata_i = word[W-1];
    rises = 0; lat = 0; phase_bad = 0; rearm = 0;
    @(negedge clk);
    fsync_ni = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      lat++;
      if (sclk_oe_o) break;
    end
    prev_s = sclk_o;
    run_len = 1;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (!sclk_oe_o) break;
      if (sclk_o != prev_s) begin
        if (run_len != DIV) phase_bad++;
        run_len = 1;
        if (sclk_o) begin
          rises++;
          if (abort_at > 0 && rises == abort_at) fsync_ni = 1'b1;
        end else if (rises < W) begin
          sdata_i = word[W-1-rises];
        end
      end else begin
        run_len++;
      end
      prev_s = sclk_o;
    end
    for (int i = 0; i < hold_low; i++) begin
      @(negedge clk);
      if (sclk_oe_o || !sclk_o) rearm++;
    end
    fsync_ni = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_case(input bit sel, input logic [W-1:0] word, input int abort_at,
                         input int hold_low);
    int rises, lat, pbad, rearm;
    run_frame(sel, word, abort_at, hold_low, rises, lat, pbad, rearm);
    chk(lat == 3, "R2", "clock start latency", lat, 3);
    chk(pbad == 0, "R6", "phase length errors", pbad, 0);
    if (abort_at == 0) begin
      chk(rises == W, "R3", "rising edges per frame", rises, W);
      if (sel) exp_cal = word; else exp_ctrl = word;
    end
    if (hold_low > 0) chk(rearm == 0, "R8", "activity while held low", rearm, 0);
    if (abort_at == 0) begin
      chk(sel ? (cal_reg_o == exp_cal) : (ctrl_reg_o == exp_ctrl), "R4",
          "received word msb first", sel ? cal_reg_o : ctrl_reg_o, word);
      chk(sel ? (ctrl_reg_o == exp_ctrl) : (cal_reg_o == exp_cal), "R5",
          "unselected register kept", sel ? ctrl_reg_o : cal_reg_o,
          sel ? exp_ctrl : exp_cal);
    end else begin
      chk(ctrl_reg_o == exp_ctrl, "R7", "ctrl after abort", ctrl_reg_o, exp_ctrl);
      chk(cal_reg_o == exp_cal, "R7", "cal after abort", cal_reg_o, exp_cal);
      chk(!sclk_oe_o && sclk_o, "R7", "line released after abort",
          {sclk_oe_o, sclk_o}, 2'b01);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0713));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!sclk_oe_o, "R1", "oe after reset", sclk_oe_o, 0);
    chk(sclk_o, "R1", "sclk after reset", sclk_o, 1);
    chk(ctrl_reg_o == '0, "R1", "ctrl after reset", ctrl_reg_o, 0);
    chk(cal_reg_o == '0, "R1", "cal after reset", cal_reg_o, 0);

    do_case(1'b0, 24'hA5C30F, 0, 0);
    do_case(1'b1, 24'h800001, 0, 0);
    do_case(1'b0, 24'hFFFFFF, 0, 40);
    do_case(1'b1, 24'h000000, 0, 0);
    do_case(1'b0, 24'h123456, 1, 0);
    do_case(1'b1, 24'h654321, 23, 0);
    do_case(1'b1, 24'h7FFFFE, 0, 0);

    for (int n = 0; n < 30; n++) begin
      logic [W-1:0] w;
      int ab, hl;
      w  = W'($urandom);
      ab = (($urandom % 4) == 0) ? int'($urandom_range(1, W-1)) : 0;
      hl = (($urandom % 5) == 0) ? 20 : 0;
      do_case(1'($urandom), w, ab, hl);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule